// File: doc/BRIEF.md
# Montgomery Ladder Scalar Multiplication Controller

This block sequences the multiplication of a base point G by a scalar k on a short-Weierstrass curve. It does so with the Montgomery ladder. It holds two working points, A and B, in Jacobian coordinates (X, Y, Z). It consumes the scalar one bit per iteration, starting at the most significant bit. The curve formulas and the field arithmetic live outside the block. Four request/acknowledge ports reach them: a point adder, a point doubler, a Z inverter and a field multiplier.

Every iteration requests both the sum A+B and one doubling. The scalar bit does not decide whether work is done. It only decides which working point is doubled and where the two results land. The number of iterations is fixed by the scalar width.

After the last bit, the controller checks A's Z coordinate. If Z is zero, the block reports the point at infinity. Otherwise it requests Z⁻² and Z⁻³ from the inverter and forms the affine result with two multiplies.

Top module: `ladder_scalar_mul`

## Requirements
- R1: After reset, busy, done, res_inf and every request output are low.
- R2: A start pulse while busy is low raises busy on the next cycle. The block ignores start while busy is high: it neither restarts nor changes the scalar it is working on.
- R3: A run makes exactly WORD_W×NUM_WORDS iterations, whatever the scalar value. Each iteration raises one adder request and one doubler request, both in the same cycle.
- R4: Scalar word i occupies bits [i·WORD_W+WORD_W−1 : i·WORD_W]. The iterations visit the scalar from bit WORD_W×NUM_WORDS−1 down to bit 0. The doubler operand is working point A when the current bit is 0 and working point B when it is 1.
- R5: The adder always receives (A, B). Let S be the sum and T the double. On bit 0 the block sets A←T and B←S. On bit 1 it sets B←T and A←S.
- R6: At start, A is set to the point at infinity, encoded as (1, 1, 0), and B is set to (gx, gy, 1).
- R7: A raised request keeps its operands stable and stays high until its acknowledge arrives. The acknowledge is a single-cycle pulse that carries the result.
- R8: When A's final Z is nonzero, the block requests the inverse of that Z. It then multiplies X by Z⁻², then Y by Z⁻³, and presents the two products as res_x and res_y.
- R9: When A's final Z is zero, res_inf is 1 and res_x = res_y = 0. No inverter or multiplier request is raised in that run.
- R10: done is a single-cycle pulse, and busy is low during it. The results stay unchanged until the next accepted start.
- R11: A new iteration's requests are raised only after both S and T are captured. The two acknowledges may arrive in either order or in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication |
| scalar | input | WORD_W*NUM_WORDS | Scalar k, sampled at start |
| gx | input | CW | Base point x |
| gy | input | CW | Base point y |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| res_x | output | CW | Affine x of k·G |
| res_y | output | CW | Affine y of k·G |
| res_inf | output | 1 | Result is the point at infinity |
| add_req | output | 1 | Point-add request |
| add_ax | output | CW | First addend X |
| add_ay | output | CW | First addend Y |
| add_az | output | CW | First addend Z |
| add_bx | output | CW | Second addend X |
| add_by | output | CW | Second addend Y |
| add_bz | output | CW | Second addend Z |
| add_ack | input | 1 | Sum valid |
| add_rx | input | CW | Sum X |
| add_ry | input | CW | Sum Y |
| add_rz | input | CW | Sum Z |
| dbl_req | output | 1 | Point-double request |
| dbl_px | output | CW | Operand X |
| dbl_py | output | CW | Operand Y |
| dbl_pz | output | CW | Operand Z |
| dbl_ack | input | 1 | Double valid |
| dbl_rx | input | CW | Double X |
| dbl_ry | input | CW | Double Y |
| dbl_rz | input | CW | Double Z |
| inv_req | output | 1 | Inversion request |
| inv_z | output | CW | Value to invert |
| inv_ack | input | 1 | Inverse valid |
| inv_z2 | input | CW | Squared inverse |
| inv_z3 | input | CW | Cubed inverse |
| mul_req | output | 1 | Field multiply request |
| mul_a | output | CW | Multiplicand |
| mul_b | output | CW | Multiplier |
| mul_ack | input | 1 | Product valid |
| mul_p | input | CW | Product |

## Verification
Several behaviours are hard to reach from the ports. The first is a final A with Z equal to zero while B still holds a finite point. The bench reaches it with scalar 0 and with scalars equal to the group order. It finds that order by repeated addition over a small prime field.

The second is a sum acknowledged before, after or together with its double. This would expose an early writeback. The bench staggers the two acknowledge latencies differently in every iteration.

The third is a swap that selects the wrong register. Responders that rescale Z by a changing factor make it visible. Every working point then has a distinct Jacobian form, and the bench compares the adder and doubler operands with its own shadow of A and B in every iteration.

// File: rtl/ladder_pkg.sv
`timescale 1ns/1ps
package ladder_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOOP = 3'd1,
        ST_WB   = 3'd2,
        ST_INV  = 3'd3,
        ST_MULX = 3'd4,
        ST_MULY = 3'd5
    } lad_state_e;

endpackage

// File: rtl/ladder_bit_scan.sv
`timescale 1ns/1ps
module ladder_bit_scan #(
    parameter int KW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [KW-1:0] scalar,
    output logic          cur_bit,
    output logic          last
);
    localparam int CNT_W = (KW > 1) ? $clog2(KW) : 1;

    logic [KW-1:0]    sh_d, sh_q;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        sh_d  = sh_q;
        cnt_d = cnt_q;
        if (load) begin
            sh_d  = scalar;
            cnt_d = CNT_W'(KW - 1);
        end else if (step) begin
            sh_d  = sh_q << 1;
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else begin
            sh_q  <= sh_d;
            cnt_q <= cnt_d;
        end
    end

    assign cur_bit = sh_q[KW-1];
    assign last    = (cnt_q == '0);

endmodule

// File: rtl/ladder_route.sv
`timescale 1ns/1ps
module ladder_route #(
    parameter int PW = 48
) (
    input  logic          cur_bit,
    input  logic [PW-1:0] pa,
    input  logic [PW-1:0] pb,
    input  logic [PW-1:0] sum,
    input  logic [PW-1:0] dbl,
    output logic [PW-1:0] dbl_src,
    output logic [PW-1:0] na,
    output logic [PW-1:0] nb
);
    always_comb begin
        if (cur_bit) begin
            dbl_src = pb;
            na      = sum;
            nb      = dbl;
        end else begin
            dbl_src = pa;
            na      = dbl;
            nb      = sum;
        end
    end
endmodule

// File: rtl/ladder_scalar_mul.sv
`timescale 1ns/1ps
module ladder_scalar_mul
    import ladder_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int NUM_WORDS = 2,
    parameter int CW        = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [WORD_W*NUM_WORDS-1:0] scalar,
    input  logic [CW-1:0]               gx,
    input  logic [CW-1:0]               gy,
    output logic                        busy,
    output logic                        done,
    output logic [CW-1:0]               res_x,
    output logic [CW-1:0]               res_y,
    output logic                        res_inf,
    output logic                        add_req,
    output logic [CW-1:0]               add_ax,
    output logic [CW-1:0]               add_ay,
    output logic [CW-1:0]               add_az,
    output logic [CW-1:0]               add_bx,
    output logic [CW-1:0]               add_by,
    output logic [CW-1:0]               add_bz,
    input  logic                        add_ack,
    input  logic [CW-1:0]               add_rx,
    input  logic [CW-1:0]               add_ry,
    input  logic [CW-1:0]               add_rz,
    output logic                        dbl_req,
    output logic [CW-1:0]               dbl_px,
    output logic [CW-1:0]               dbl_py,
    output logic [CW-1:0]               dbl_pz,
    input  logic                        dbl_ack,
    input  logic [CW-1:0]               dbl_rx,
    input  logic [CW-1:0]               dbl_ry,
    input  logic [CW-1:0]               dbl_rz,
    output logic                        inv_req,
    output logic [CW-1:0]               inv_z,
    input  logic                        inv_ack,
    input  logic [CW-1:0]               inv_z2,
    input  logic [CW-1:0]               inv_z3,
    output logic                        mul_req,
    output logic [CW-1:0]               mul_a,
    output logic [CW-1:0]               mul_b,
    input  logic                        mul_ack,
    input  logic [CW-1:0]               mul_p
);
    localparam int KW = WORD_W * NUM_WORDS;
    localparam int PW = 3 * CW;
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef logic [CW-1:0] crd_t;
    typedef struct packed {
        crd_t x;
        crd_t y;
        crd_t z;
    } jpt_t;

    typedef struct packed {
        lad_state_e st;
        jpt_t       pa;
        jpt_t       pb;
        jpt_t       sum;
        jpt_t       dbl;
        logic       add_req;
        logic       dbl_req;
        logic       inv_req;
        logic       mul_req;
        crd_t       mul_a;
        crd_t       mul_b;
        crd_t       z3;
        crd_t       rx;
        crd_t       ry;
        logic       inf;
        logic       done;
    } ctl_t;

    ctl_t n, q;
    logic scan_load, scan_step, cur_bit, last;
    jpt_t dbl_src, na, nb;

    ladder_bit_scan #(.KW(KW)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (scan_load),
        .step    (scan_step),
        .scalar  (scalar),
        .cur_bit (cur_bit),
        .last    (last)
    );

    ladder_route #(.PW(PW)) u_route (
        .cur_bit (cur_bit),
        .pa      (q.pa),
        .pb      (q.pb),
        .sum     (q.sum),
        .dbl     (q.dbl),
        .dbl_src (dbl_src),
        .na      (na),
        .nb      (nb)
    );

    always_comb begin
        n         = q;
        n.done    = 1'b0;
        scan_load = 1'b0;
        scan_step = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    n.pa.x    = ONE;
                    n.pa.y    = ONE;
                    n.pa.z    = '0;
                    n.pb.x    = gx;
                    n.pb.y    = gy;
                    n.pb.z    = ONE;
                    n.add_req = 1'b1;
                    n.dbl_req = 1'b1;
                    scan_load = 1'b1;
                    n.st      = ST_LOOP;
                end
            end
            ST_LOOP: begin
                if (q.add_req && add_ack) begin
                    n.sum     = '{x: add_rx, y: add_ry, z: add_rz};
                    n.add_req = 1'b0;
                end
                if (q.dbl_req && dbl_ack) begin
                    n.dbl     = '{x: dbl_rx, y: dbl_ry, z: dbl_rz};
                    n.dbl_req = 1'b0;
                end
                if (!n.add_req && !n.dbl_req) begin
                    n.st = ST_WB;
                end
            end
            ST_WB: begin
                n.pa      = na;
                n.pb      = nb;
                scan_step = 1'b1;
                if (!last) begin
                    n.add_req = 1'b1;
                    n.dbl_req = 1'b1;
                    n.st      = ST_LOOP;
                end else if (na.z == '0) begin
                    n.rx   = '0;
                    n.ry   = '0;
                    n.inf  = 1'b1;
                    n.done = 1'b1;
                    n.st   = ST_IDLE;
                end else begin
                    n.inv_req = 1'b1;
                    n.st      = ST_INV;
                end
            end
            ST_INV: begin
                if (inv_ack) begin
                    n.inv_req = 1'b0;
                    n.z3      = inv_z3;
                    n.mul_req = 1'b1;
                    n.mul_a   = q.pa.x;
                    n.mul_b   = inv_z2;
                    n.st      = ST_MULX;
                end
            end
            ST_MULX: begin
                if (mul_ack) begin
                    n.rx    = mul_p;
                    n.mul_a = q.pa.y;
                    n.mul_b = q.z3;
                    n.st    = ST_MULY;
                end
            end
            ST_MULY: begin
                if (mul_ack) begin
                    n.mul_req = 1'b0;
                    n.ry      = mul_p;
                    n.inf     = 1'b0;
                    n.done    = 1'b1;
                    n.st      = ST_IDLE;
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign busy    = (q.st != ST_IDLE);
    assign done    = q.done;
    assign res_x   = q.rx;
    assign res_y   = q.ry;
    assign res_inf = q.inf;
    assign add_req = q.add_req;
    assign add_ax  = q.pa.x;
    assign add_ay  = q.pa.y;
    assign add_az  = q.pa.z;
    assign add_bx  = q.pb.x;
    assign add_by  = q.pb.y;
    assign add_bz  = q.pb.z;
    assign dbl_req = q.dbl_req;
    assign dbl_px  = dbl_src.x;
    assign dbl_py  = dbl_src.y;
    assign dbl_pz  = dbl_src.z;
    assign inv_req = q.inv_req;
    assign inv_z   = q.pa.z;
    assign mul_req = q.mul_req;
    assign mul_a   = q.mul_a;
    assign mul_b   = q.mul_b;

endmodule

// File: rtl/ladder_chk.sv
`timescale 1ns/1ps
module ladder_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          add_req,
    input logic          add_ack,
    input logic [CW-1:0] add_ax,
    input logic [CW-1:0] add_ay,
    input logic [CW-1:0] add_az,
    input logic [CW-1:0] add_bx,
    input logic [CW-1:0] add_by,
    input logic [CW-1:0] add_bz,
    input logic          dbl_req,
    input logic          dbl_ack,
    input logic [CW-1:0] dbl_px,
    input logic [CW-1:0] dbl_py,
    input logic [CW-1:0] dbl_pz,
    input logic          inv_req,
    input logic [CW-1:0] inv_z,
    input logic          mul_req,
    input logic          mul_ack,
    input logic [CW-1:0] mul_a,
    input logic [CW-1:0] mul_b
);
    // R2
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R3
    paired_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(add_req) |-> $rose(dbl_req));

    // R7
    add_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add_req && !add_ack) |=> (add_req && $stable({add_ax, add_ay, add_az, add_bx, add_by, add_bz})));

    // R7
    dbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_req && !dbl_ack) |=> (dbl_req && $stable({dbl_px, dbl_py, dbl_pz})));

    // R7
    mul_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_req && !mul_ack) |=> (mul_req && $stable({mul_a, mul_b})));

    // R8
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({add_req | dbl_req, inv_req, mul_req}));

    // R9
    inv_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_req |-> (inv_z != '0));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind ladder_scalar_mul ladder_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .add_req (add_req),
    .add_ack (add_ack),
    .add_ax  (add_ax),
    .add_ay  (add_ay),
    .add_az  (add_az),
    .add_bx  (add_bx),
    .add_by  (add_by),
    .add_bz  (add_bz),
    .dbl_req (dbl_req),
    .dbl_ack (dbl_ack),
    .dbl_px  (dbl_px),
    .dbl_py  (dbl_py),
    .dbl_pz  (dbl_pz),
    .inv_req (inv_req),
    .inv_z   (inv_z),
    .mul_req (mul_req),
    .mul_ack (mul_ack),
    .mul_a   (mul_a),
    .mul_b   (mul_b)
);

// File: tb/sim_ladder_scalar_mul.sv
`timescale 1ns/1ps
module sim_ladder_scalar_mul;
    localparam int WW = 8;
    localparam int NW = 2;
    localparam int CW = 16;
    localparam int KW = WW * NW;
    localparam int P  = 97;
    localparam int CA = P - 3;
    localparam int GX = 3;
    localparam int GY = 6;

    typedef struct { int x; int y; bit inf; } apt_t;
    typedef struct { int x; int y; int z; } jpt_t;
    typedef struct { int x; int y; bit inf; int k; } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [KW-1:0] scalar = '0;
    logic busy, done, res_inf, add_req, dbl_req, inv_req, mul_req;
    logic [CW-1:0] res_x, res_y, add_ax, add_ay, add_az, add_bx, add_by, add_bz;
    logic [CW-1:0] dbl_px, dbl_py, dbl_pz, inv_z, mul_a, mul_b;
    logic add_ack = 1'b0, dbl_ack = 1'b0, inv_ack = 1'b0, mul_ack = 1'b0;
    logic [CW-1:0] add_rx = '0, add_ry = '0, add_rz = '0;
    logic [CW-1:0] dbl_rx = '0, dbl_ry = '0, dbl_rz = '0;
    logic [CW-1:0] inv_z2 = '0, inv_z3 = '0, mul_p = '0;

    always #2.5 clk = ~clk;

    ladder_scalar_mul #(.WORD_W(WW), .NUM_WORDS(NW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .scalar(scalar),
        .gx(CW'(GX)), .gy(CW'(GY)), .busy(busy), .done(done),
        .res_x(res_x), .res_y(res_y), .res_inf(res_inf),
        .add_req(add_req), .add_ax(add_ax), .add_ay(add_ay), .add_az(add_az),
        .add_bx(add_bx), .add_by(add_by), .add_bz(add_bz), .add_ack(add_ack),
        .add_rx(add_rx), .add_ry(add_ry), .add_rz(add_rz),
        .dbl_req(dbl_req), .dbl_px(dbl_px), .dbl_py(dbl_py), .dbl_pz(dbl_pz),
        .dbl_ack(dbl_ack), .dbl_rx(dbl_rx), .dbl_ry(dbl_ry), .dbl_rz(dbl_rz),
        .inv_req(inv_req), .inv_z(inv_z), .inv_ack(inv_ack),
        .inv_z2(inv_z2), .inv_z3(inv_z3),
        .mul_req(mul_req), .mul_a(mul_a), .mul_b(mul_b),
        .mul_ack(mul_ack), .mul_p(mul_p)
    );

    int checks = 0;
    int fails = 0;
    exp_t sbq[$];
    jpt_t sh_a, sh_b;
    logic [KW-1:0] cur_k = '0;
    int iter = 0, add_cnt = 0, inv_cnt = 0, mul_cnt = 0, lam_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int md(input int v);
        return ((v % P) + P) % P;
    endfunction

    function automatic int minv(input int v);
        int r = 1;
        int b = md(v);
        for (int e = P - 2; e > 0; e = e >> 1) begin
            if (e[0]) r = md(r * b);
            b = md(b * b);
        end
        return r;
    endfunction

    function automatic apt_t padd(input apt_t a, input apt_t b);
        apt_t r;
        int lam;
        if (a.inf) return b;
        if (b.inf) return a;
        r.inf = 1'b0;
        if (a.x == b.x) begin
            if (md(a.y + b.y) == 0) begin
                r.inf = 1'b1; r.x = 0; r.y = 0;
                return r;
            end
            lam = md(md(3 * md(a.x * a.x) + CA) * minv(2 * a.y));
        end else begin
            lam = md(md(b.y - a.y) * minv(b.x - a.x));
        end
        r.x = md(md(lam * lam) - a.x - b.x);
        r.y = md(md(lam * md(a.x - r.x)) - a.y);
        return r;
    endfunction

    function automatic apt_t to_aff(input jpt_t j);
        apt_t r;
        int zi;
        if (md(j.z) == 0) begin
            r.inf = 1'b1; r.x = 0; r.y = 0;
        end else begin
            zi = minv(j.z);
            r.inf = 1'b0;
            r.x = md(j.x * md(zi * zi));
            r.y = md(j.y * md(md(zi * zi) * zi));
        end
        return r;
    endfunction

    function automatic jpt_t to_jac(input apt_t a, input int lam);
        jpt_t j;
        if (a.inf) begin
            j.x = 1; j.y = 1; j.z = 0;
        end else begin
            j.x = md(a.x * md(lam * lam));
            j.y = md(a.y * md(md(lam * lam) * lam));
            j.z = lam;
        end
        return j;
    endfunction

    function automatic apt_t ref_mul(input logic [KW-1:0] k);
        apt_t r, g;
        r.inf = 1'b1; r.x = 0; r.y = 0;
        g.inf = 1'b0; g.x = GX; g.y = GY;
        for (int i = KW - 1; i >= 0; i--) begin
            r = padd(r, r);
            if (k[i]) r = padd(r, g);
        end
        return r;
    endfunction

    function automatic int group_order();
        apt_t g, acc;
        int n = 1;
        g.inf = 1'b0; g.x = GX; g.y = GY;
        acc = g;
        while (!acc.inf && n < 400) begin
            acc = padd(acc, g);
            n++;
        end
        return n;
    endfunction

    function automatic int next_lam();
        lam_cnt++;
        return 1 + (lam_cnt % (P - 1));
    endfunction

    // adder/doubler responder with a shadow of both working points
    initial begin
        forever begin
            @(negedge clk);
            if (add_req && dbl_req) begin
                bit b;
                jpt_t opa, opb, opd, sres, tres, expd;
                int la, ld, mx;
                b = cur_k[KW - 1 - iter];
                opa = '{int'(add_ax), int'(add_ay), int'(add_az)};
                opb = '{int'(add_bx), int'(add_by), int'(add_bz)};
                opd = '{int'(dbl_px), int'(dbl_py), int'(dbl_pz)};
                expd = b ? sh_b : sh_a;
                // R6 on the first iteration, R5 and R11 afterwards
                chk(opa == sh_a && opb == sh_b, (iter == 0) ? "R6" : "R5 R11",
                    "adder operand A.x", opa.x, sh_a.x);
                // R4 operand chosen by the scalar bit, msb first
                chk(opd == expd, "R4", "doubler operand z", opd.z, expd.z);
                sres = to_jac(padd(to_aff(opa), to_aff(opb)), next_lam());
                tres = to_jac(padd(to_aff(opd), to_aff(opd)), next_lam());
                if (b) begin sh_b = tres; sh_a = sres; end
                else   begin sh_a = tres; sh_b = sres; end
                add_cnt++;
                iter++;
                la = iter % 3;
                ld = (iter + 1) % 2;
                mx = ((la > ld) ? la : ld) + 1;
                add_rx = CW'(sres.x); add_ry = CW'(sres.y); add_rz = CW'(sres.z);
                dbl_rx = CW'(tres.x); dbl_ry = CW'(tres.y); dbl_rz = CW'(tres.z);
                for (int c = 0; c < mx; c++) begin
                    add_ack = (c == la);
                    dbl_ack = (c == ld);
                    @(negedge clk);
                end
                add_ack = 1'b0;
                dbl_ack = 1'b0;
            end
        end
    end

    // inverter responder
    initial begin
        forever begin
            @(negedge clk);
            if (inv_req) begin
                int zi;
                inv_cnt++;
                // R8 the inverted value is A's final Z
                chk(int'(inv_z) == sh_a.z, "R8", "inverter operand", int'(inv_z), sh_a.z);
                zi = minv(int'(inv_z));
                inv_z2 = CW'(md(zi * zi));
                inv_z3 = CW'(md(md(zi * zi) * zi));
                @(negedge clk);
                inv_ack = 1'b1;
                @(negedge clk);
                inv_ack = 1'b0;
            end
        end
    end

    // multiplier responder
    initial begin
        forever begin
            @(negedge clk);
            if (mul_req) begin
                int zi, ea, eb;
                mul_cnt++;
                zi = minv(sh_a.z);
                ea = (mul_cnt == 1) ? sh_a.x : sh_a.y;
                eb = (mul_cnt == 1) ? md(zi * zi) : md(md(zi * zi) * zi);
                // R8 X times squared inverse, then Y times cubed inverse
                chk(int'(mul_a) == ea && int'(mul_b) == eb, "R8", "multiply operand a",
                    int'(mul_a), ea);
                mul_p = CW'(md(int'(mul_a) * int'(mul_b)));
                mul_ack = 1'b1;
                @(negedge clk);
                mul_ack = 1'b0;
            end
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                exp_t e;
                if (sbq.size() == 0) begin
                    chk(1'b0, "R10", "unexpected done", 1, 0);
                end else begin
                    e = sbq.pop_front();
                    chk(res_inf == e.inf, e.inf ? "R9" : "R8", "res_inf", int'(res_inf), int'(e.inf));
                    chk(int'(res_x) == e.x, e.inf ? "R9" : "R8", "res_x", int'(res_x), e.x);
                    chk(int'(res_y) == e.y, e.inf ? "R9" : "R8", "res_y", int'(res_y), e.y);
                    // R10 busy low during done
                    chk(busy == 1'b0, "R10", "busy with done", int'(busy), 0);
                    // R3 fixed iteration count
                    chk(add_cnt == KW, "R3", "iterations", add_cnt, KW);
                    if (e.inf) begin
                        // R9 no inversion or multiply on infinity
                        chk(inv_cnt == 0 && mul_cnt == 0, "R9", "inv+mul requests",
                            inv_cnt + mul_cnt, 0);
                    end else begin
                        chk(inv_cnt == 1 && mul_cnt == 2, "R8", "mul requests", mul_cnt, 2);
                    end
                end
            end
        end
    end

    task automatic run_case(input logic [KW-1:0] k, input bit restart);
        apt_t r;
        exp_t e;
        r = ref_mul(k);
        e.inf = r.inf;
        e.x = r.inf ? 0 : r.x;
        e.y = r.inf ? 0 : r.y;
        e.k = int'(k);
        sbq.push_back(e);
        iter = 0; add_cnt = 0; inv_cnt = 0; mul_cnt = 0;
        sh_a = '{1, 1, 0};
        sh_b = '{GX, GY, 1};
        cur_k = k;
        scalar = k;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2 busy one cycle after start
        chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        if (restart) begin
            repeat (7) @(negedge clk);
            scalar = ~k;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            scalar = k;
        end
        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);
        // R10 results held after done
        chk(res_inf == e.inf && int'(res_x) == e.x, "R10", "held res_x", int'(res_x), e.x);
    endtask

    initial begin
        int n;
        n = group_order();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !res_inf, "R1", "busy/done/inf in reset",
            int'({busy, done, res_inf}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!add_req && !dbl_req && !inv_req && !mul_req, "R1", "requests after reset",
            int'({add_req, dbl_req, inv_req, mul_req}), 0);
        run_case(KW'(0), 1'b0);
        run_case(KW'(1), 1'b0);
        run_case(KW'(16'h00A5), 1'b0);
        run_case(KW'(16'h5A00), 1'b0);
        run_case(KW'(16'hFFFF), 1'b0);
        run_case(KW'(n), 1'b0);
        run_case(KW'(n + 1), 1'b0);
        run_case(KW'(2 * n), 1'b0);
        run_case(KW'(16'h8001), 1'b0);
        // R2 start while busy is ignored
        run_case(KW'(16'h0137), 1'b1);
        repeat (5) @(negedge clk);
        chk(sbq.size() == 0, "R10", "pending results", sbq.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule